// File: doc/BRIEF.md
# Registered DIMM Control-Word Sequencer

This block performs the power-up programming of the sixteen 4-bit control words held in the register device of a registered DDR3 DIMM. A one-cycle `start` pulse launches it. It then idles long enough for the register to activate and for its PLL to lock. Next it drives a chip-select mask for the chosen DIMM and walks the control-word numbers upward from 0 to 15. For each word it inserts a mode-register gap and works out the word's value. It folds the word number and the value into a bank/address pair and offers that pair on a downstream command port. A final stabilisation wait closes the sequence, and the block signals that it has finished.

The command port is a valid/ready stream. When `cmd_valid` rises, `cmd_bank` and `cmd_addr` hold steady and `cmd_valid` stays high for as long as `cmd_ready` is low. The transfer happens at the first rising edge where both are high, and `cmd_valid` falls at that same edge. The downstream side can stall for any number of cycles, and the sequencer just waits. All delays are given in microseconds and converted to clock cycles through a clock-frequency parameter.

Top module: `rdimm_cw_seq`

## Requirements
- R1: While reset (synchronous, active high) is applied and after it is released, `busy`, `done` and `cmd_valid` are 0 and `cs_mask` is all zeros.
- R2: After `start` is taken in idle, no command is offered during the first (T_ACT_US+T_PLL_US)·CLK_MHZ cycles. `busy` is 1 from the cycle after `start` until completion.
- R3: From the end of the settle wait until completion, `cs_mask` equals 2'b11 shifted left by 2×`dimm_sel`, with `dimm_sel` captured at start and every other bit 0. Outside that window `cs_mask` is 0.
- R4: Control words go out in ascending order from 0 to 15, and words 6 and 7 are never offered, so a run makes exactly 14 transfers.
- R5: Each of the 16 word slots, skipped ones included, begins with a gap of T_MRD_US·CLK_MHZ cycles. The gap counts from the end of the settle wait or from the previous transfer edge, and `cmd_valid` rises when it ends.
- R6: Word values are 0x2 for word 0, 0xC for word 1 and 0xD for word 9. Words 3, 4 and 5 take nibble `dimm_sel` (bits [4·d+3:4·d]) of `rc3_cfg`, `rc4_cfg` and `rc5_cfg`. Every other word is 0.
- R7: `cmd_bank` = {word[3], value[3:2]}, `cmd_addr[4:3]` = value[1:0], `cmd_addr[2:0]` = word[2:0], and `cmd_addr` bits above 4 are 0.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_bank` and `cmd_addr` hold. After the transfer edge `cmd_valid` is 0.
- R9: T_STAB_US·CLK_MHZ cycles after the last transfer edge, `done` pulses for exactly one cycle. At the same edge `busy` falls and `cs_mask` clears.
- R10: A `start` pulse while `busy` is 1 has no effect: the transfer count, the values and the timing of the current run stay the same, and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken only when idle |
| dimm_sel | input | IDX_W | Target DIMM index, captured at start |
| rc3_cfg | input | 4·NUM_DIMMS | Per-DIMM nibbles for word 3 |
| rc4_cfg | input | 4·NUM_DIMMS | Per-DIMM nibbles for word 4 |
| rc5_cfg | input | 4·NUM_DIMMS | Per-DIMM nibbles for word 5 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| cs_mask | output | 2·NUM_DIMMS | Chip-select mask of the target DIMM |
| cmd_valid | output | 1 | Command offered downstream |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_bank | output | 3 | Bank lines of the command |
| cmd_addr | output | ADDR_W | Address lines of the command |

## Verification
The bench predicts the exact transfer edge of every word. A design that left out the gaps of the skipped slots 6 and 7, or counted a gap from the wrong edge, would put words 8 to 15 and `done` early. The bench runs with zero-latency and stalling downstream responders. A sequencer that let the bank/address pair change under back-pressure, or that fired twice, would show a changed hold value or 15 or more transfers. Different DIMM indices and configuration nibbles catch a wrong nibble or a wrong mask shift. A `start` pulse in the middle of a run, and a reset during a stalled transfer, expose a sequence that restarts or does not clear its outputs.

// File: rtl/rdimm_cw_pkg.sv
package rdimm_cw_pkg;

  localparam int WORD_W = 4;
  localparam int VAL_W  = 4;
  localparam int BANK_W = 3;
  localparam int NUM_WORDS = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_GAP,
    ST_SEND,
    ST_STAB
  } seq_state_t;

  function automatic logic word_skipped(input logic [WORD_W-1:0] w);
    return (w == 4'd6) || (w == 4'd7);
  endfunction

endpackage

// File: rtl/rdimm_cw_timer.sv
module rdimm_cw_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  // A load of N makes expired true in the N-th cycle after the load.
  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val - 1'b1;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/rdimm_cw_value.sv
module rdimm_cw_value #(
  parameter int NUM_DIMMS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [3:0]             word,
  input  logic [IDX_W-1:0]       idx,
  input  logic [NUM_DIMMS*4-1:0] rc3_cfg,
  input  logic [NUM_DIMMS*4-1:0] rc4_cfg,
  input  logic [NUM_DIMMS*4-1:0] rc5_cfg,
  output logic [3:0]             value
);
  logic [3:0] nib3 [NUM_DIMMS];
  logic [3:0] nib4 [NUM_DIMMS];
  logic [3:0] nib5 [NUM_DIMMS];

  for (genvar d = 0; d < NUM_DIMMS; d++) begin : g_nib
    assign nib3[d] = rc3_cfg[4*d +: 4];
    assign nib4[d] = rc4_cfg[4*d +: 4];
    assign nib5[d] = rc5_cfg[4*d +: 4];
  end

  logic [3:0] sel3, sel4, sel5;
  always_comb begin
    sel3 = '0;
    sel4 = '0;
    sel5 = '0;
    for (int d = 0; d < NUM_DIMMS; d++) begin
      if (32'(idx) == d) begin
        sel3 = nib3[d];
        sel4 = nib4[d];
        sel5 = nib5[d];
      end
    end
  end

  always_comb begin
    unique case (word)
      4'd0:    value = 4'h2;
      4'd1:    value = 4'hC;
      4'd3:    value = sel3;
      4'd4:    value = sel4;
      4'd5:    value = sel5;
      4'd9:    value = 4'hD;
      default: value = 4'h0;
    endcase
  end

endmodule

// File: rtl/rdimm_cw_encode.sv
module rdimm_cw_encode #(
  parameter int ADDR_W = 16
) (
  input  logic [3:0]        word,
  input  logic [3:0]        value,
  output logic [2:0]        bank,
  output logic [ADDR_W-1:0] addr
);
  assign bank = {word[3], value[3:2]};

  assign addr[4:0] = {value[1:0], word[2:0]};
  if (ADDR_W > 5) begin : g_hi
    assign addr[ADDR_W-1:5] = '0;
  end

endmodule

// File: rtl/rdimm_cw_seq.sv
module rdimm_cw_seq #(
  parameter int CLK_MHZ   = 400,
  parameter int NUM_DIMMS = 4,
  parameter int ADDR_W    = 16,
  parameter int T_ACT_US  = 8,
  parameter int T_PLL_US  = 6,
  parameter int T_MRD_US  = 8,
  parameter int T_STAB_US = 6,
  localparam int IDX_W    = (NUM_DIMMS > 1) ? $clog2(NUM_DIMMS) : 1,
  localparam int CS_W     = 2 * NUM_DIMMS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [IDX_W-1:0]       dimm_sel,
  input  logic [NUM_DIMMS*4-1:0] rc3_cfg,
  input  logic [NUM_DIMMS*4-1:0] rc4_cfg,
  input  logic [NUM_DIMMS*4-1:0] rc5_cfg,
  output logic                   busy,
  output logic                   done,
  output logic [CS_W-1:0]        cs_mask,
  output logic                   cmd_valid,
  input  logic                   cmd_ready,
  output logic [2:0]             cmd_bank,
  output logic [ADDR_W-1:0]      cmd_addr
);
  import rdimm_cw_pkg::*;

  localparam int SETTLE_CYC = CLK_MHZ * (T_ACT_US + T_PLL_US);
  localparam int GAP_CYC    = CLK_MHZ * T_MRD_US;
  localparam int STAB_CYC   = CLK_MHZ * T_STAB_US;
  localparam int MAX_A      = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int MAX_CYC    = (MAX_A > STAB_CYC) ? MAX_A : STAB_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  seq_state_t        st, st_nx;
  logic [3:0]        word, word_nx;
  logic [IDX_W-1:0]  idx, idx_nx;
  logic [CS_W-1:0]   cs_nx;
  logic              valid_nx, done_nx;
  logic              tmr_load, tmr_exp;
  logic [CNT_W-1:0]  tmr_val;
  logic [3:0]        cur_val;
  logic [2:0]        enc_bank;
  logic [ADDR_W-1:0] enc_addr;

  rdimm_cw_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  rdimm_cw_value #(.NUM_DIMMS(NUM_DIMMS), .IDX_W(IDX_W)) u_value (
    .word(word), .idx(idx), .rc3_cfg(rc3_cfg), .rc4_cfg(rc4_cfg),
    .rc5_cfg(rc5_cfg), .value(cur_val)
  );

  rdimm_cw_encode #(.ADDR_W(ADDR_W)) u_enc (
    .word(word), .value(cur_val), .bank(enc_bank), .addr(enc_addr)
  );

  always_comb begin
    st_nx    = st;
    word_nx  = word;
    idx_nx   = idx;
    cs_nx    = cs_mask;
    valid_nx = cmd_valid;
    done_nx  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = CNT_W'(GAP_CYC);
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          st_nx    = ST_SETTLE;
          word_nx  = '0;
          idx_nx   = dimm_sel;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(SETTLE_CYC);
        end
      end
      ST_SETTLE: begin
        if (tmr_exp) begin
          st_nx    = ST_GAP;
          cs_nx    = CS_W'(2'b11) << {idx, 1'b0};
          tmr_load = 1'b1;
        end
      end
      ST_GAP: begin
        if (tmr_exp) begin
          if (word_skipped(word)) begin
            word_nx  = word + 1'b1;
            tmr_load = 1'b1;
          end else begin
            st_nx    = ST_SEND;
            valid_nx = 1'b1;
          end
        end
      end
      ST_SEND: begin
        if (cmd_ready) begin
          valid_nx = 1'b0;
          tmr_load = 1'b1;
          if (word == 4'(NUM_WORDS - 1)) begin
            st_nx   = ST_STAB;
            tmr_val = CNT_W'(STAB_CYC);
          end else begin
            st_nx   = ST_GAP;
            word_nx = word + 1'b1;
          end
        end
      end
      ST_STAB: begin
        if (tmr_exp) begin
          st_nx   = ST_IDLE;
          done_nx = 1'b1;
          cs_nx   = '0;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      word      <= '0;
      idx       <= '0;
      cs_mask   <= '0;
      cmd_valid <= 1'b0;
      done      <= 1'b0;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
    end else begin
      st        <= st_nx;
      word      <= word_nx;
      idx       <= idx_nx;
      cs_mask   <= cs_nx;
      cmd_valid <= valid_nx;
      done      <= done_nx;
      if (valid_nx && !cmd_valid) begin
        cmd_bank <= enc_bank;
        cmd_addr <= enc_addr;
      end
    end
  end

  assign busy = (st != ST_IDLE);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_bank) && $stable(cmd_addr)));

  a_r8_drop: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  a_r4_no_skipped_word: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !(cmd_bank[2] == 1'b0 && cmd_addr[2:1] == 2'b11));

  a_r3_cs_shape: assert property (@(posedge clk) disable iff (rst)
    ($countones(cs_mask) == 0) || ($countones(cs_mask) == 2 && busy));

  a_r2_quiet_settle: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETTLE) |-> (!cmd_valid && cs_mask == '0));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && cs_mask == '0) ##1 !done);

endmodule

// File: tb/rdimm_cw_seq_tb.sv
module rdimm_cw_seq_tb;
  localparam int CLK_MHZ = 2;
  localparam int ND      = 4;
  localparam int AW      = 16;
  localparam int SETTLE  = CLK_MHZ * 14;
  localparam int GAP     = CLK_MHZ * 8;
  localparam int STAB    = CLK_MHZ * 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    dimm_sel = '0;
  logic [15:0]   rc3_cfg = 16'hA5C3;
  logic [15:0]   rc4_cfg = 16'h7E19;
  logic [15:0]   rc5_cfg = 16'hB06F;
  logic          busy, done, cmd_valid;
  logic          cmd_ready = 1'b0;
  logic [7:0]    cs_mask;
  logic [2:0]    cmd_bank;
  logic [AW-1:0] cmd_addr;

  rdimm_cw_seq #(.CLK_MHZ(CLK_MHZ), .NUM_DIMMS(ND), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .dimm_sel(dimm_sel),
    .rc3_cfg(rc3_cfg), .rc4_cfg(rc4_cfg), .rc5_cfg(rc5_cfg),
    .busy(busy), .done(done), .cs_mask(cs_mask),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr)
  );

  always #2.5ns clk = ~clk;

  int gcyc = 0;
  always @(posedge clk) gcyc <= gcyc + 1;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Downstream responder with programmable stall, logs each transfer.
  int          lat = 0;
  int          wcnt = 0;
  int          n_xfer = 0;
  int          hold_bad = 0;
  logic [2:0]  hb;
  logic [AW-1:0] ha;
  logic [2:0]  lb [32];
  logic [AW-1:0] la [32];
  int          le [32];

  always @(negedge clk) begin
    if (cmd_ready) cmd_ready = 1'b0;
    else if (cmd_valid && !rst) begin
      if (wcnt == 0) begin
        hb = cmd_bank;
        ha = cmd_addr;
      end else if (cmd_bank != hb || cmd_addr != ha) hold_bad++;
      if (wcnt == lat) begin
        cmd_ready = 1'b1;
        if (n_xfer < 32) begin
          lb[n_xfer] = cmd_bank;
          la[n_xfer] = cmd_addr;
          le[n_xfer] = gcyc + 1;
        end
        n_xfer++;
        wcnt = 0;
      end else wcnt++;
    end else wcnt = 0;
  end

  function automatic logic [3:0] exp_val(input int w, input int d);
    case (w)
      0: return 4'h2;
      1: return 4'hC;
      3: return rc3_cfg[4*d +: 4];
      4: return rc4_cfg[4*d +: 4];
      5: return rc5_cfg[4*d +: 4];
      9: return 4'hD;
      default: return 4'h0;
    endcase
  endfunction

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
    check(cs_mask == 8'h00, "R1 cs_mask", cs_mask, 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && cs_mask == 8'h00, "R1 idle after release", busy, 0);
  endtask

  task automatic t_run(input int d, input int l, input int restart_at, input string tag);
    int s, done_e, k, cs_bad, early, t, idx;
    logic [7:0] exp_cs;
    dimm_sel = 2'(d);
    lat = l;
    n_xfer = 0;
    hold_bad = 0;
    cs_bad = 0;
    early = 0;
    done_e = -1;
    exp_cs = 8'b11 << (2 * d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    s = gcyc;
    check(busy == 1'b1, {"R2 busy after start ", tag}, busy, 1);
    for (k = 0; k < 5000; k++) begin
      if (k == restart_at) start = 1'b1;
      else start = 1'b0;
      if (gcyc < s + SETTLE && (cmd_valid || cs_mask != 0)) early++;
      if (gcyc >= s + SETTLE && busy && cs_mask != exp_cs) cs_bad++;
      if (done) begin
        done_e = gcyc;
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(early == 0, {"R2 quiet during settle ", tag}, early, 0);
    check(cs_bad == 0, {"R3 cs_mask during run ", tag}, cs_bad, 0);
    check(hold_bad == 0, {"R8 hold under stall ", tag}, hold_bad, 0);
    check(n_xfer == 14, {"R4 transfer count ", tag}, n_xfer, 14);
    check(busy == 1'b0 && cs_mask == 8'h00, {"R9 released with done ", tag}, cs_mask, 0);
    // Walk the expected schedule.
    t = s + SETTLE;
    idx = 0;
    for (int w = 0; w < 16; w++) begin
      logic [3:0] v;
      t = t + GAP;
      if (w == 6 || w == 7) continue;
      t = t + 1 + l;
      v = exp_val(w, d);
      if (idx < n_xfer && idx < 32) begin
        check(lb[idx] == {w[3], v[3:2]}, $sformatf("R6 R7 bank word %0d %s", w, tag),
              lb[idx], {w[3], v[3:2]});
        check(la[idx] == {11'b0, v[1:0], w[2:0]}, $sformatf("R6 R7 addr word %0d %s", w, tag),
              la[idx], {11'b0, v[1:0], w[2:0]});
        check(le[idx] == t, $sformatf("R5 transfer edge word %0d %s", w, tag), le[idx], t);
      end
      idx++;
    end
    check(done_e == t + STAB, {"R9 done timing ", tag}, done_e, t + STAB);
    @(negedge clk);
    check(done == 1'b0, {"R9 done one cycle ", tag}, done, 0);
    if (restart_at >= 0) begin
      int extra = 0;
      repeat (80) begin
        if (cmd_valid || busy) extra++;
        @(negedge clk);
      end
      check(extra == 0, {"R10 no second run ", tag}, extra, 0);
    end
  endtask

  task automatic t_reset_midrun;
    int k;
    lat = 100000;
    dimm_sel = 2'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (k = 0; k < 200 && !cmd_valid; k++) @(negedge clk);
    check(cmd_valid == 1'b1 && cs_mask == 8'h0C, "R3 stalled mask for dimm 1", cs_mask, 8'h0C);
    rst = 1'b1;
    @(negedge clk);
    check(cmd_valid == 1'b0 && busy == 1'b0, "R1 reset during stall", cmd_valid, 0);
    check(cs_mask == 8'h00 && done == 1'b0, "R1 reset clears mask", cs_mask, 0);
    rst = 1'b0;
    lat = 0;
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_run(0, 0, -1, "dimm0 no stall");
    t_run(2, 3, -1, "dimm2 stall3");
    rc3_cfg = 16'hF000;
    rc4_cfg = 16'h8111;
    rc5_cfg = 16'h5EEE;
    t_run(3, 1, 100, "dimm3 restart pulse R10");
    t_reset_midrun();
    t_run(1, 0, -1, "dimm1 after reset");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule